// File: doc/BRIEF.md
# DMA Descriptor Register Bank

This block is the software-facing register bank of a scatter-gather DMA engine. It sits on a 32-bit Wishbone slave port with byte enables. It holds one transfer descriptor: a local-side address, a 64-bit host address, a byte count, a 64-bit pointer to the next descriptor, and a direction/chain attribute pair. The engine reads all of these values as plain output wires.

Software starts or abandons a transfer by writing command bits in the control word. These bits are not stored; each one becomes a single-clock pulse to the engine. The control word also holds a two-bit byte-swap mode, and every control write produces a write-strobe pulse.

In the other direction, the engine drives a two-bit state code, which software reads from the status word. The engine also raises an interrupt-set pulse, which latches a sticky flag. Software clears the flag by writing one to it.

The port has no back-pressure. Every access is acknowledged exactly one clock after it is presented, so a master never waits longer than that.

Top module: `dma_desc_regs`

## Requirements
- R1: An access presented with cycle and strobe high is acknowledged by a one-clock `wb_ack_o` in the following cycle. Read data is valid while `wb_ack_o` is high. The port never stalls.
- R2: Writing 1 to control (offset 0x00) bit 0, with byte lane 0 enabled, raises `start_o` for exactly one clock, in the acknowledge cycle. The bit is not stored and reads back as 0.
- R3: Writing 1 to control bit 1, with byte lane 0 enabled, raises `abort_o` for exactly one clock, in the acknowledge cycle. The bit reads back as 0.
- R4: Control bits 3:2 store the byte-swap mode, which drives `swap_mode_o`. Every write to offset 0x00 pulses `ctrl_wr_o` for one clock.
- R5: Status (offset 0x04) bits 1:0 return `eng_state_i`, encoded as 00 idle, 01 busy, 10 error and 11 aborted.
- R6: Status bit 2 is a sticky interrupt flag, also driven on `irq_o`. A pulse on `eng_irq_set_i` sets it. A write with bit 2 = 1 and lane 0 enabled clears it. Writing 0 to the bit leaves it unchanged. When a set and a clear arrive in the same cycle, the set wins.
- R7: Offsets 0x08 (local address), 0x0C and 0x10 (host address, low and high words), 0x14 (length), and 0x18 and 0x1C (next pointer, low and high words) are 32-bit read/write registers. Each byte lane is written only when its `wb_sel_i` bit is set. `host_addr_o` and `next_ptr_o` are formed as {high word, low word}.
- R8: Attribute (offset 0x20) bit 0 drives `dir_o` (0 = toward host, 1 = toward local side), and bit 1 drives `chain_o`. Unused bits of every register read as 0. Offsets above 0x20 read as 0, and writes to them change nothing.
- R9: A synchronous reset on `rst_i` clears all stored fields, the interrupt flag, the acknowledge and the pulses to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 6 | Byte address; bits 5:2 select the word |
| wb_sel_i | input | 4 | Byte-lane enables |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| eng_state_i | input | 2 | Engine state code |
| eng_irq_set_i | input | 1 | Interrupt-set pulse from the engine |
| start_o | output | 1 | Start pulse |
| abort_o | output | 1 | Abort pulse |
| swap_mode_o | output | 2 | Byte-swap mode |
| ctrl_wr_o | output | 1 | Control-write strobe |
| loc_addr_o | output | 32 | Local-side start address |
| host_addr_o | output | 64 | Host start address |
| len_o | output | 32 | Transfer length in bytes |
| next_ptr_o | output | 64 | Next-descriptor pointer |
| dir_o | output | 1 | Direction |
| chain_o | output | 1 | Chain flag |
| irq_o | output | 1 | Interrupt flag |

## Verification
Each storage word is written with a distinct value and read back, so an offset decode that aliases two words shows up as a wrong readback. Partial byte-enable writes on both the low and the high lanes separate lane gating from whole-word writes. Writing all ones to the control and attribute words exposes command or unused bits that leak into readback. The interrupt flag is driven through set-only, write-zero, write-one and same-cycle set-plus-clear patterns, which separates the priority order from plain clear logic.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int IDX_W   = 4;
  localparam int STORE_N = 6;
  localparam int STORE_BASE = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL = 4'd0,
    IDX_STAT = 4'd1,
    IDX_LOC  = 4'd2,
    IDX_HLO  = 4'd3,
    IDX_HHI  = 4'd4,
    IDX_LEN  = 4'd5,
    IDX_NLO  = 4'd6,
    IDX_NHI  = 4'd7,
    IDX_ATTR = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {
    ENG_IDLE    = 2'b00,
    ENG_BUSY    = 2'b01,
    ENG_ERROR   = 2'b10,
    ENG_ABORTED = 2'b11
  } eng_state_e;
endpackage

// File: rtl/dma_desc_bus.sv
module dma_desc_bus (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cyc_i,
  input  logic stb_i,
  output logic acc_o,
  output logic ack_o
);
  logic ack_q;

  assign acc_o = cyc_i && stb_i && !ack_q;
  assign ack_o = ack_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) ack_q <= 1'b0;
    else       ack_q <= acc_o;
  end
endmodule

// File: rtl/dma_desc_store.sv
module dma_desc_store #(
  parameter int N  = 6,
  parameter int DW = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [N-1:0]          we_i,
  input  logic [DW/8-1:0]       sel_i,
  input  logic [DW-1:0]         dat_i,
  output logic [N-1:0][DW-1:0]  q_o
);
  localparam int LN = DW / 8;

  for (genvar w = 0; w < N; w++) begin : g_word
    for (genvar b = 0; b < LN; b++) begin : g_lane
      always_ff @(posedge clk_i) begin
        if (rst_i)
          q_o[w][b*8 +: 8] <= 8'h00;
        else if (we_i[w] && sel_i[b])
          q_o[w][b*8 +: 8] <= dat_i[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/dma_desc_irq.sv
module dma_desc_irq (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)      flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_desc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [3:0]        wb_sel_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  input  logic [1:0]        eng_state_i,
  input  logic              eng_irq_set_i,
  output logic              start_o,
  output logic              abort_o,
  output logic [1:0]        swap_mode_o,
  output logic              ctrl_wr_o,
  output logic [31:0]       loc_addr_o,
  output logic [63:0]       host_addr_o,
  output logic [31:0]       len_o,
  output logic [63:0]       next_ptr_o,
  output logic              dir_o,
  output logic              chain_o,
  output logic              irq_o
);
  logic                              acc;
  logic [IDX_W-1:0]                  idx;
  logic                              wr_acc;
  logic                              hit_ctrl;
  logic                              hit_attr;
  logic                              irq_clr;
  logic [STORE_N-1:0]                st_we;
  logic [STORE_N-1:0][DATA_W-1:0]    st_q;
  logic [DATA_W-1:0]                 rd_word;

  assign idx      = wb_adr_i[5:2];
  assign wr_acc   = acc && wb_we_i;
  assign hit_ctrl = wr_acc && (idx == IDX_CTRL);
  assign hit_attr = wr_acc && (idx == IDX_ATTR) && wb_sel_i[0];
  assign irq_clr  = wr_acc && (idx == IDX_STAT) && wb_sel_i[0] && wb_dat_i[2];

  dma_desc_bus u_bus (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cyc_i (wb_cyc_i),
    .stb_i (wb_stb_i),
    .acc_o (acc),
    .ack_o (wb_ack_o)
  );

  for (genvar w = 0; w < STORE_N; w++) begin : g_we
    assign st_we[w] = wr_acc && (idx == IDX_W'(w + STORE_BASE));
  end

  dma_desc_store #(.N(STORE_N), .DW(DATA_W)) u_store (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .we_i  (st_we),
    .sel_i (wb_sel_i),
    .dat_i (wb_dat_i),
    .q_o   (st_q)
  );

  dma_desc_irq u_irq (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .set_i  (eng_irq_set_i),
    .clr_i  (irq_clr),
    .flag_o (irq_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      start_o     <= 1'b0;
      abort_o     <= 1'b0;
      ctrl_wr_o   <= 1'b0;
      swap_mode_o <= 2'b00;
      dir_o       <= 1'b0;
      chain_o     <= 1'b0;
    end else begin
      start_o   <= hit_ctrl && wb_sel_i[0] && wb_dat_i[0];
      abort_o   <= hit_ctrl && wb_sel_i[0] && wb_dat_i[1];
      ctrl_wr_o <= hit_ctrl;
      if (hit_ctrl && wb_sel_i[0]) swap_mode_o <= wb_dat_i[3:2];
      if (hit_attr) begin
        dir_o   <= wb_dat_i[0];
        chain_o <= wb_dat_i[1];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (idx)
      IDX_CTRL: rd_word = {28'd0, swap_mode_o, 2'b00};
      IDX_STAT: rd_word = {29'd0, irq_o, eng_state_i};
      IDX_ATTR: rd_word = {30'd0, chain_o, dir_o};
      default: begin
        if (idx >= IDX_W'(STORE_BASE) && idx < IDX_W'(STORE_BASE + STORE_N))
          rd_word = st_q[3'(idx - IDX_W'(STORE_BASE))];
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                  wb_dat_o <= '0;
    else if (acc && !wb_we_i)   wb_dat_o <= rd_word;
    else                        wb_dat_o <= '0;
  end

  assign loc_addr_o  = st_q[IDX_LOC - STORE_BASE];
  assign host_addr_o = {st_q[IDX_HHI - STORE_BASE], st_q[IDX_HLO - STORE_BASE]};
  assign len_o       = st_q[IDX_LEN - STORE_BASE];
  assign next_ptr_o  = {st_q[IDX_NHI - STORE_BASE], st_q[IDX_NLO - STORE_BASE]};
endmodule

// File: rtl/dma_desc_regs_chk.sv
module dma_desc_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wb_cyc_i,
  input logic              wb_stb_i,
  input logic              wb_we_i,
  input logic [ADDR_W-1:0] wb_adr_i,
  input logic [3:0]        wb_sel_i,
  input logic [31:0]       wb_dat_i,
  input logic              wb_ack_o,
  input logic              eng_irq_set_i,
  input logic              start_o,
  input logic              abort_o,
  input logic              irq_o
);
  assert_ack_next_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

  assert_ack_single_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    wb_ack_o |=> !wb_ack_o);

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    start_o |=> !start_o);

  assert_start_cause_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    start_o |-> ($past(wb_stb_i && wb_we_i && wb_dat_i[0] && wb_sel_i[0]) && wb_ack_o));

  assert_abort_pulse_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    abort_o |=> !abort_o);

  assert_irq_set_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    eng_irq_set_i |=> irq_o);

  assert_irq_clear_cause_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(irq_o) && $past(!rst_i)) |->
      $past(wb_cyc_i && wb_stb_i && wb_we_i && wb_adr_i[5:2] == 4'd1
            && wb_sel_i[0] && wb_dat_i[2]));
endmodule

bind dma_desc_regs dma_desc_regs_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dma_desc_regs_tb_top.sv
module dma_desc_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_i = 1'b1;
  logic        wb_cyc_i = 1'b0, wb_stb_i = 1'b0, wb_we_i = 1'b0;
  logic [5:0]  wb_adr_i = '0;
  logic [3:0]  wb_sel_i = '0;
  logic [31:0] wb_dat_i = '0;
  logic [31:0] wb_dat_o;
  logic        wb_ack_o;
  logic [1:0]  eng_state_i = 2'b00;
  logic        eng_irq_set_i = 1'b0;
  logic        start_o, abort_o, ctrl_wr_o, dir_o, chain_o, irq_o;
  logic [1:0]  swap_mode_o;
  logic [31:0] loc_addr_o, len_o;
  logic [63:0] host_addr_o, next_ptr_o;

  int vecs = 0;
  int errs = 0;
  logic [31:0] rd_s;
  logic ack_s, start_s, abort_s, cw_s, irq_s;

  always #5 clk_i = ~clk_i;

  dma_desc_regs dut_i (.*);

  // {we, adr, sel, wdata, expected read}
  localparam int NV = 22;
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 6'h08, 4'hF, 32'hA5A5_1234, 32'h0},
    {1'b0, 6'h08, 4'hF, 32'h0,         32'hA5A5_1234},
    {1'b1, 6'h0C, 4'h3, 32'hFFFF_BEEF, 32'h0},
    {1'b0, 6'h0C, 4'hF, 32'h0,         32'h0000_BEEF},
    {1'b1, 6'h10, 4'hF, 32'h1111_2222, 32'h0},
    {1'b0, 6'h10, 4'hF, 32'h0,         32'h1111_2222},
    {1'b1, 6'h14, 4'hF, 32'h0000_1000, 32'h0},
    {1'b0, 6'h14, 4'hF, 32'h0,         32'h0000_1000},
    {1'b1, 6'h18, 4'hF, 32'hDEAD_0000, 32'h0},
    {1'b0, 6'h18, 4'hF, 32'h0,         32'hDEAD_0000},
    {1'b1, 6'h1C, 4'hF, 32'h0000_0042, 32'h0},
    {1'b0, 6'h1C, 4'hF, 32'h0,         32'h0000_0042},
    {1'b1, 6'h20, 4'hF, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 6'h20, 4'hF, 32'h0,         32'h0000_0003},
    {1'b1, 6'h00, 4'hF, 32'h0000_000F, 32'h0},
    {1'b0, 6'h00, 4'hF, 32'h0,         32'h0000_000C},
    {1'b0, 6'h24, 4'hF, 32'h0,         32'h0},
    {1'b1, 6'h24, 4'hF, 32'h1234_5678, 32'h0},
    {1'b0, 6'h24, 4'hF, 32'h0,         32'h0},
    {1'b1, 6'h08, 4'h8, 32'h7700_0000, 32'h0},
    {1'b0, 6'h08, 4'hF, 32'h0,         32'h77A5_1234},
    {1'b0, 6'h04, 4'hF, 32'h0,         32'h0000_0001}
  };

  function automatic string tag_of(input logic [5:0] a);
    case (a[5:2])
      4'd0: return "R2/R3/R4";
      4'd1: return "R5";
      4'd8: return "R8";
      default: return (a[5:2] > 4'd8) ? "R8" : "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [5:0] adr, input logic [3:0] sel,
                        input logic [31:0] dat, input logic irq_pulse);
    @(negedge clk_i);
    wb_cyc_i = 1'b1; wb_stb_i = 1'b1; wb_we_i = we;
    wb_adr_i = adr;  wb_sel_i = sel;  wb_dat_i = dat;
    eng_irq_set_i = irq_pulse;
    @(negedge clk_i);
    rd_s = wb_dat_o; ack_s = wb_ack_o; start_s = start_o;
    abort_s = abort_o; cw_s = ctrl_wr_o; irq_s = irq_o;
    wb_cyc_i = 1'b0; wb_stb_i = 1'b0; wb_we_i = 1'b0;
    eng_irq_set_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_i = 1'b0;
    @(negedge clk_i);
    // R9: reset state at the ports
    chk("R9 ack", {63'd0, wb_ack_o}, 64'd0);
    chk("R9 host", host_addr_o, 64'd0);
    chk("R9 next", next_ptr_o, 64'd0);
    chk("R9 misc", {loc_addr_o, len_o}, 64'd0);
    chk("R9 flags", {58'd0, irq_o, dir_o, chain_o, swap_mode_o, start_o}, 64'd0);

    eng_state_i = 2'b01;
    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][74], VEC[i][73:68], VEC[i][67:64], VEC[i][63:32], 1'b0);
      chk("R1 ack", {63'd0, ack_s}, 64'd1);
      if (!VEC[i][74]) chk(tag_of(VEC[i][73:68]), {32'd0, rd_s}, {32'd0, VEC[i][31:0]});
      if (i == 14) begin
        chk("R2 start pulse", {63'd0, start_s}, 64'd1);
        chk("R3 abort pulse", {63'd0, abort_s}, 64'd1);
        chk("R4 ctrl strobe", {63'd0, cw_s}, 64'd1);
      end
    end
    @(negedge clk_i);
    chk("R1 ack dropped", {63'd0, wb_ack_o}, 64'd0);
    chk("R2 start one clock", {62'd0, start_o, abort_o}, 64'd0);
    chk("R7 host out", host_addr_o, 64'h1111_2222_0000_BEEF);
    chk("R7 next out", next_ptr_o, 64'h0000_0042_DEAD_0000);
    chk("R7 loc/len", {loc_addr_o, len_o}, 64'h77A5_1234_0000_1000);
    chk("R8 attr out", {62'd0, chain_o, dir_o}, 64'd3);
    chk("R4 swap out", {62'd0, swap_mode_o}, 64'd3);

    // R2: start alone, swap rewritten to 0
    bus_op(1'b1, 6'h00, 4'hF, 32'h1, 1'b0);
    chk("R2 start only", {61'd0, start_s, abort_s, cw_s}, 64'b101);
    chk("R4 swap cleared", {62'd0, swap_mode_o}, 64'd0);
    // R2: lane 0 disabled -> no pulse, strobe still
    bus_op(1'b1, 6'h00, 4'hE, 32'hF, 1'b0);
    chk("R2 lane gated", {61'd0, start_s, abort_s, cw_s}, 64'b001);
    // R4: non-control write gives no strobe
    bus_op(1'b1, 6'h14, 4'hF, 32'h5, 1'b0);
    chk("R4 no strobe", {63'd0, cw_s}, 64'd0);

    // R5: all state codes
    for (int s = 0; s < 4; s++) begin
      eng_state_i = 2'(s);
      bus_op(1'b0, 6'h04, 4'hF, 32'h0, 1'b0);
      chk("R5 state", {32'd0, rd_s}, 64'(s));
    end

    // R6: interrupt flag behaviour
    eng_state_i = 2'b00;
    @(negedge clk_i); eng_irq_set_i = 1'b1;
    @(negedge clk_i); eng_irq_set_i = 1'b0;
    chk("R6 set", {63'd0, irq_o}, 64'd1);
    bus_op(1'b0, 6'h04, 4'hF, 32'h0, 1'b0);
    chk("R6 read flag", {32'd0, rd_s}, 64'h4);
    bus_op(1'b1, 6'h04, 4'hF, 32'h0, 1'b0);
    chk("R6 write zero keeps", {63'd0, irq_s}, 64'd1);
    bus_op(1'b1, 6'h04, 4'hF, 32'h4, 1'b0);
    chk("R6 clear", {63'd0, irq_s}, 64'd0);
    bus_op(1'b1, 6'h04, 4'hF, 32'h4, 1'b1);
    chk("R6 set wins", {63'd0, irq_s}, 64'd1);

    // R9: reset mid-run
    @(negedge clk_i); rst_i = 1'b1;
    @(negedge clk_i); rst_i = 1'b0;
    chk("R9 re-reset", {irq_o, dir_o, chain_o, swap_mode_o, len_o, 27'd0}, 64'd0);
    chk("R9 re-reset host", host_addr_o, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule